// File: doc/BRIEF.md
# Multi-Bus Slot Hotplug Controller

This block lets firmware find, and then eject, hot-pluggable devices that sit on several buses. For every bus it keeps three 32-bit masks, one bit per slot: devices present, slots that allow hotplug, and removals waiting for the guest to finish. It also keeps two masks that the firmware never reads: which slots hold a device, and which of those devices are flagged not removable.

A small word-wide register window gives firmware its view of these masks. A select register chooses the bus, and reads and ejects act on that bus. The platform reports boot-time presence, hot-add and hot-remove events, each tagged with a bus number, a slot and a not-removable flag. A hot-add or hot-remove sets bit 1 of an event status byte, and that bit drives the interrupt line.

A platform rebuild strobe stands in for a system reset. It completes every pending removal and then rebuilds the present and hotplug-enable masks from the slots that are still occupied.

Top module: `slot_hp_ctrl`

## Requirements
- R1: After the asynchronous reset, every bus has present = 0, pending = 0 and hotplug-enable = 0xFFFFFFFF. Select is 0 and the status byte and irq are 0.
- R2: Reads act on the selected bus. Offset 0x00 returns present AND hotplug-enable, offset 0x0C returns hotplug-enable, and offset 0x08 always returns 0.
- R3: Offset 0x04 returns the pending-removal mask of the selected bus.
- R4: A write to offset 0x10 stores the 32-bit select value. Reading 0x10 returns it. Every read returns 0 while select is NUM_BUS or above.
- R5: Only accesses with bus_full = 1 to one of the five word offsets 0x00, 0x04, 0x08, 0x0C and 0x10 (address bits [1:0] = 0) are accepted. Any other write changes nothing, and any other read returns 0.
- R6: ev_kind selects the event: 0 is boot-time presence, 1 is hot-add, 2 is hot-remove, and 3 is ignored. Boot presence and hot-add set the slot's present bit and record it as occupied, with ev_fixed as its not-removable flag. Hot-remove sets the slot's pending bit. Only hot-add and hot-remove raise the status. Events whose bus is NUM_BUS or above are ignored.
- R7: A write to offset 0x08 ejects on the selected bus. It takes the lowest set bit of the data as the slot and clears that slot's pending bit. It also clears the slot's present bit, unless the slot holds a device flagged not removable. The write is ignored when select is NUM_BUS or above, or when the data is 0.
- R8: Status bit 1 (value 0x02) of ev_sts is set by an accepted hot-add or hot-remove. A 1 on sts_clr[1] clears it, and a set in the same cycle takes priority over the clear. irq equals that bit, and all other status bits stay 0.
- R9: A cycle with plat_rebuild = 1 completes every pending removal on every bus and clears the pending masks. Present becomes the set of slots still occupied. Hotplug-enable becomes all ones except for the occupied slots flagged not removable. A rebuild takes priority over an eject or event in the same cycle.
- R10: bus_rdata and bus_rvalid are registered. They show a read one cycle after bus_rd, and bus_rvalid is 0 in the cycle after a cycle without bus_rd.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| plat_rebuild | input | 1 | Platform reset strobe: completes removals and rebuilds masks |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_full | input | 1 | Access is a full 32-bit word |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |
| ev_valid | input | 1 | Platform event strobe |
| ev_kind | input | 2 | 0 boot presence, 1 hot-add, 2 hot-remove |
| ev_bus | input | BUS_ID_W | Bus number of the event |
| ev_slot | input | 5 | Slot number of the event |
| ev_fixed | input | 1 | Device is not removable |
| sts_clr | input | 8 | Write-one-to-clear for the status byte |
| ev_sts | output | 8 | Event status byte (bit 1 = slot hotplug event) |
| irq | output | 1 | Interrupt, level |

## Verification
The checker assumes that ev_kind, ev_bus and the strobes carry known values in every cycle after reset. It also assumes that the interrupt can rise only because a hot event was accepted in the cycle before, so sts_clr must never be used to set bits. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It returns ev_kind to a value with ev_valid low between events, and writes sts_clr only with single clear bits, so those assumptions hold throughout.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;

    localparam int MASK_W = 32;
    localparam int SLOT_IDX_W = $clog2(MASK_W);

    typedef logic [MASK_W-1:0] mask_t;

    typedef enum logic [1:0] {
        EV_BOOT   = 2'd0,
        EV_ADD    = 2'd1,
        EV_REMOVE = 2'd2,
        EV_NONE   = 2'd3
    } ev_kind_e;

    typedef enum logic [2:0] {
        REG_UP,
        REG_DOWN,
        REG_EJECT,
        REG_RMV,
        REG_SEL,
        REG_NONE
    } reg_e;

    localparam int OFF_UP    = 'h00;
    localparam int OFF_DOWN  = 'h04;
    localparam int OFF_EJECT = 'h08;
    localparam int OFF_RMV   = 'h0C;
    localparam int OFF_SEL   = 'h10;

    localparam int STS_HP_BIT = 1;

    typedef struct packed {
        mask_t pres;
        mask_t hpen;
        mask_t down;
        mask_t occ;
        mask_t fixd;
    } bank_t;

endpackage

// File: rtl/slot_hp_lowbit.sv
module slot_hp_lowbit #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] low_o
);
    // isolate the least significant set bit
    always_comb begin
        low_o = vec_i & (~vec_i + {{(W-1){1'b0}}, 1'b1});
    end
endmodule

// File: rtl/slot_hp_decode.sv
module slot_hp_decode
    import slot_hp_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              full_i,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_e              rd_reg_o,
    output logic              wr_eject_o,
    output logic              wr_sel_o
);
    reg_e hit;

    always_comb begin
        hit = REG_NONE;
        if (full_i && addr_i[1:0] == 2'b00) begin
            case (int'(addr_i))
                OFF_UP:    hit = REG_UP;
                OFF_DOWN:  hit = REG_DOWN;
                OFF_EJECT: hit = REG_EJECT;
                OFF_RMV:   hit = REG_RMV;
                OFF_SEL:   hit = REG_SEL;
                default:   hit = REG_NONE;
            endcase
        end
        rd_reg_o   = rd_i ? hit : REG_NONE;
        wr_eject_o = wr_i && (hit == REG_EJECT);
        wr_sel_o   = wr_i && (hit == REG_SEL);
    end
endmodule

// File: rtl/slot_hp_bank.sv
module slot_hp_bank
    import slot_hp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rebuild_i,
    input  logic       ej_en_i,
    input  mask_t      ej_mask_i,
    input  logic       ev_en_i,
    input  logic [1:0] ev_kind_i,
    input  mask_t      ev_mask_i,
    input  logic       ev_fixed_i,
    output mask_t      pres_o,
    output mask_t      hpen_o,
    output mask_t      down_o
);
    bank_t bank_d, bank_q;
    mask_t keep;

    always_comb begin
        bank_d = bank_q;
        // occupied slots that survive completion of every pending removal
        keep = bank_q.occ & ~(bank_q.down & ~bank_q.fixd);
        if (rebuild_i) begin
            bank_d.occ  = keep;
            bank_d.fixd = bank_q.fixd & keep;
            bank_d.pres = keep;
            bank_d.hpen = ~(keep & bank_q.fixd);
            bank_d.down = '0;
        end else begin
            if (ej_en_i) begin
                bank_d.down = bank_d.down & ~ej_mask_i;
                if ((bank_q.occ & bank_q.fixd & ej_mask_i) == '0) begin
                    bank_d.pres = bank_d.pres & ~ej_mask_i;
                    bank_d.occ  = bank_d.occ & ~ej_mask_i;
                    bank_d.fixd = bank_d.fixd & ~ej_mask_i;
                end
            end
            if (ev_en_i) begin
                case (ev_kind_e'(ev_kind_i))
                    EV_BOOT, EV_ADD: begin
                        bank_d.pres = bank_d.pres | ev_mask_i;
                        bank_d.occ  = bank_d.occ | ev_mask_i;
                        bank_d.fixd = (bank_d.fixd & ~ev_mask_i)
                                    | (ev_fixed_i ? ev_mask_i : '0);
                    end
                    EV_REMOVE: bank_d.down = bank_d.down | ev_mask_i;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.pres <= '0;
            bank_q.hpen <= '1;
            bank_q.down <= '0;
            bank_q.occ  <= '0;
            bank_q.fixd <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pres_o = bank_q.pres;
    assign hpen_o = bank_q.hpen;
    assign down_o = bank_q.down;
endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
    import slot_hp_pkg::*;
#(
    parameter int NUM_BUS  = 8,
    parameter int BUS_ID_W = 4,
    parameter int ADDR_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                plat_rebuild,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic                bus_full,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic                ev_valid,
    input  logic [1:0]          ev_kind,
    input  logic [BUS_ID_W-1:0] ev_bus,
    input  logic [4:0]          ev_slot,
    input  logic                ev_fixed,
    input  logic [7:0]          sts_clr,
    output logic [7:0]          ev_sts,
    output logic                irq
);
    localparam int IDX_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

    typedef struct packed {
        logic [31:0] sel;
        logic [31:0] rdata;
        logic        rvalid;
        logic [7:0]  sts;
    } top_t;

    top_t st_d, st_q;

    reg_e        rd_reg;
    logic        wr_eject, wr_sel;
    logic        sel_ok;
    logic [IDX_W-1:0] sel_idx;
    mask_t       ej_low;
    mask_t       ev_mask;
    logic        ev_in_range;
    logic        hot_ev;
    mask_t       pres_a [NUM_BUS];
    mask_t       hpen_a [NUM_BUS];
    mask_t       down_a [NUM_BUS];
    mask_t       pres_s, hpen_s, down_s;

    slot_hp_decode #(.ADDR_W(ADDR_W)) u_dec (
        .rd_i      (bus_rd),
        .wr_i      (bus_wr),
        .full_i    (bus_full),
        .addr_i    (bus_addr),
        .rd_reg_o  (rd_reg),
        .wr_eject_o(wr_eject),
        .wr_sel_o  (wr_sel)
    );

    slot_hp_lowbit #(.W(MASK_W)) u_low (
        .vec_i(bus_wdata),
        .low_o(ej_low)
    );

    assign sel_ok      = st_q.sel < 32'(NUM_BUS);
    assign sel_idx     = st_q.sel[IDX_W-1:0];
    assign ev_in_range = int'(ev_bus) < NUM_BUS;
    assign ev_mask     = mask_t'(1) << ev_slot;
    assign hot_ev      = ev_valid && ev_in_range
                      && (ev_kind == EV_ADD || ev_kind == EV_REMOVE);

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bank
        logic ej_en_b, ev_en_b;
        assign ej_en_b = wr_eject && sel_ok && (int'(sel_idx) == b)
                      && (bus_wdata != '0);
        assign ev_en_b = ev_valid && (int'(ev_bus) == b);

        slot_hp_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .rebuild_i (plat_rebuild),
            .ej_en_i   (ej_en_b),
            .ej_mask_i (ej_low),
            .ev_en_i   (ev_en_b),
            .ev_kind_i (ev_kind),
            .ev_mask_i (ev_mask),
            .ev_fixed_i(ev_fixed),
            .pres_o    (pres_a[b]),
            .hpen_o    (hpen_a[b]),
            .down_o    (down_a[b])
        );
    end

    always_comb begin
        pres_s = '0;
        hpen_s = '0;
        down_s = '0;
        for (int b = 0; b < NUM_BUS; b++) begin
            if (sel_ok && int'(sel_idx) == b) begin
                pres_s = pres_a[b];
                hpen_s = hpen_a[b];
                down_s = down_a[b];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        st_d.rvalid = bus_rd;
        if (bus_rd) begin
            st_d.rdata = '0;
            if (sel_ok) begin
                case (rd_reg)
                    REG_UP:   st_d.rdata = pres_s & hpen_s;
                    REG_DOWN: st_d.rdata = down_s;
                    REG_RMV:  st_d.rdata = hpen_s;
                    REG_SEL:  st_d.rdata = st_q.sel;
                    default:  st_d.rdata = '0;
                endcase
            end
        end
        if (wr_sel) begin
            st_d.sel = bus_wdata;
        end
        st_d.sts = st_q.sts & ~sts_clr;
        if (hot_ev) begin
            st_d.sts[STS_HP_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign ev_sts     = st_q.sts;
    assign irq        = st_q.sts[STS_HP_BIT];
endmodule

// File: rtl/slot_hp_chk.sv
module slot_hp_chk #(
    parameter int NUM_BUS  = 8,
    parameter int BUS_ID_W = 4,
    parameter int ADDR_W   = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_rd,
    input logic                bus_full,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_rdata,
    input logic                bus_rvalid,
    input logic                ev_valid,
    input logic [1:0]          ev_kind,
    input logic [BUS_ID_W-1:0] ev_bus,
    input logic [7:0]          sts_clr,
    input logic                irq
);
    logic hot_ev;
    assign hot_ev = ev_valid && (int'(ev_bus) < NUM_BUS)
                 && (ev_kind == 2'd1 || ev_kind == 2'd2);

    // R10
    rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R10
    no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R5
    bad_access_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (!bus_full || bus_addr[1:0] != 2'b00)) |=> (bus_rdata == 32'd0));

    // R6
    hot_event_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hot_ev |=> irq);

    // R6
    irq_rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hot_ev));

    // R8
    clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr[1] && !hot_ev) |=> !irq);
endmodule

bind slot_hp_ctrl slot_hp_chk #(
    .NUM_BUS (NUM_BUS),
    .BUS_ID_W(BUS_ID_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_full  (bus_full),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid),
    .ev_valid  (ev_valid),
    .ev_kind   (ev_kind),
    .ev_bus    (ev_bus),
    .sts_clr   (sts_clr),
    .irq       (irq)
);

// File: tb/slot_hp_ctrl_tb.sv
module slot_hp_ctrl_tb;
    localparam int NUM_BUS  = 8;
    localparam int BUS_ID_W = 4;
    localparam int ADDR_W   = 5;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                plat_rebuild = 1'b0;
    logic                bus_rd = 1'b0;
    logic                bus_wr = 1'b0;
    logic                bus_full = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic                bus_rvalid;
    logic                ev_valid = 1'b0;
    logic [1:0]          ev_kind = 2'd3;
    logic [BUS_ID_W-1:0] ev_bus = '0;
    logic [4:0]          ev_slot = '0;
    logic                ev_fixed = 1'b0;
    logic [7:0]          sts_clr = '0;
    logic [7:0]          ev_sts;
    logic                irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    slot_hp_ctrl #(.NUM_BUS(NUM_BUS), .BUS_ID_W(BUS_ID_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .plat_rebuild(plat_rebuild),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_full(bus_full),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_bus(ev_bus),
        .ev_slot(ev_slot), .ev_fixed(ev_fixed), .sts_clr(sts_clr),
        .ev_sts(ev_sts), .irq(irq)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop expected read results as they appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic rd(input int addr, input logic [31:0] exp,
                      input string tag, input bit full = 1'b1);
        item_t it;
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_full = full;
        bus_addr = ADDR_W'(addr);
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        bus_rd   = 1'b0;
        bus_full = 1'b0;
    endtask

    task automatic wr(input int addr, input logic [31:0] data, input bit full = 1'b1);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_full  = full;
        bus_addr  = ADDR_W'(addr);
        bus_wdata = data;
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_full = 1'b0;
    endtask

    task automatic ev(input int kind, input int bus, input int slot,
                      input bit fixed, input logic [7:0] clr = 8'h00);
        @(negedge clk);
        ev_valid = 1'b1;
        ev_kind  = 2'(kind);
        ev_bus   = BUS_ID_W'(bus);
        ev_slot  = 5'(slot);
        ev_fixed = fixed;
        sts_clr  = clr;
        @(negedge clk);
        ev_valid = 1'b0;
        ev_kind  = 2'd3;
        sts_clr  = 8'h00;
    endtask

    task automatic clear_sts();
        @(negedge clk);
        sts_clr = 8'h02;
        @(negedge clk);
        sts_clr = 8'h00;
    endtask

    task automatic rebuild();
        @(negedge clk);
        plat_rebuild = 1'b1;
        @(negedge clk);
        plat_rebuild = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq === 1'b0, "R1 irq after reset", 32'(irq), 32'd0);
        check(ev_sts === 8'h00, "R1 status after reset", 32'(ev_sts), 32'd0);
        rd('h00, 32'h0, "R1 up after reset");
        rd('h0C, 32'hFFFF_FFFF, "R1 removable after reset");
        rd('h04, 32'h0, "R1 down after reset");
        rd('h10, 32'h0, "R1 select after reset");
        rd('h08, 32'h0, "R2 feature word reads zero");

        // R6 boot presence: no status
        ev(0, 0, 3, 1'b0);
        ev(0, 0, 5, 1'b1);
        check(irq === 1'b0, "R6 boot event raises nothing", 32'(irq), 32'd0);
        rd('h00, 32'h0000_0028, "R2 up before rebuild");

        // R9 rebuild masks the fixed slot out of enable
        rebuild();
        rd('h00, 32'h0000_0008, "R9 up after rebuild");
        rd('h0C, 32'hFFFF_FFDF, "R9 removable after rebuild");

        // R6 / R8 hot add and clear
        ev(1, 2, 0, 1'b0);
        check(irq === 1'b1, "R6 hot add raises irq", 32'(irq), 32'd1);
        check(ev_sts === 8'h02, "R8 status value", 32'(ev_sts), 32'h2);
        clear_sts();
        check(irq === 1'b0, "R8 clear drops irq", 32'(irq), 32'd0);

        // R4 select
        wr('h10, 32'd2);
        rd('h10, 32'd2, "R4 select readback");
        rd('h00, 32'h0000_0001, "R2 up on bus 2");

        // R3 pending removals
        ev(2, 2, 0, 1'b0);
        check(irq === 1'b1, "R6 hot remove raises irq", 32'(irq), 32'd1);
        ev(2, 2, 4, 1'b0);
        rd('h04, 32'h0000_0011, "R3 down on bus 2");
        clear_sts();

        // R7 eject lowest bit only
        wr('h08, 32'h0000_0030);
        rd('h04, 32'h0000_0001, "R7 eject lowest slot only");
        rd('h00, 32'h0000_0001, "R7 other slot still up");
        wr('h08, 32'h0);
        rd('h04, 32'h0000_0001, "R7 zero eject ignored");
        wr('h08, 32'h0000_0003);
        rd('h04, 32'h0, "R7 eject slot 0 down");
        rd('h00, 32'h0, "R7 eject slot 0 present cleared");

        // R7 fixed device keeps its presence
        ev(0, 3, 7, 1'b1);
        ev(0, 3, 1, 1'b0);
        ev(2, 3, 7, 1'b0);
        ev(2, 3, 1, 1'b0);
        wr('h10, 32'd3);
        rd('h04, 32'h0000_0082, "R3 down on bus 3");
        wr('h08, 32'h0000_0080);
        rd('h04, 32'h0000_0002, "R7 fixed eject clears pending");
        rd('h00, 32'h0000_0082, "R7 fixed slot stays present");
        wr('h08, 32'h0000_0002);
        rd('h00, 32'h0000_0080, "R7 removable slot gone");

        // R4 / R7 out-of-range select
        ev(2, 0, 3, 1'b0);
        wr('h10, 32'd0);
        rd('h04, 32'h0000_0008, "R3 down on bus 0");
        wr('h10, 32'd9);
        wr('h08, 32'h0000_0008);
        rd('h00, 32'h0, "R4 up reads zero out of range");
        rd('h10, 32'h0, "R4 select reads zero out of range");
        wr('h10, 32'd0);
        rd('h04, 32'h0000_0008, "R7 out-of-range eject ignored");

        // R9 rebuild completes removals
        rebuild();
        rd('h04, 32'h0, "R9 pending cleared");
        rd('h00, 32'h0, "R9 ejected slot gone");
        rd('h0C, 32'hFFFF_FFDF, "R9 bus 0 enable keeps fixed slot");
        wr('h10, 32'd3);
        rd('h0C, 32'hFFFF_FF7F, "R9 bus 3 enable");
        rd('h00, 32'h0, "R9 bus 3 up masked");

        // R5 invalid accesses
        wr('h10, 32'd5, 1'b0);
        rd('h10, 32'd3, "R5 partial write ignored");
        wr('h11, 32'd5);
        rd('h10, 32'd3, "R5 misaligned write ignored");
        rd('h02, 32'h0, "R5 misaligned read zero");
        rd('h14, 32'h0, "R5 read beyond window zero");
        rd('h0C, 32'h0, "R5 partial read zero", 1'b0);

        // R6 out-of-range bus, R8 set wins over clear
        clear_sts();
        ev(1, 8, 2, 1'b0);
        check(irq === 1'b0, "R6 event on bus 8 ignored", 32'(irq), 32'd0);
        ev(1, 4, 2, 1'b0, 8'h02);
        check(irq === 1'b1, "R8 set wins over clear", 32'(irq), 32'd1);

        // R10 no read data when idle
        @(negedge clk);
        check(bus_rvalid === 1'b0, "R10 idle rvalid", 32'(bus_rvalid), 32'd0);
        check(sb.size() == 0, "R10 all reads returned", 32'(sb.size()), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule